// File: doc/BRIEF.md
# Raster Timing and Border Colour Generator

This block keeps the beam position of a retro home-computer display, counted in CPU clock cycles (T-states). A T-state counter walks each scanline and a line counter walks each frame. A CPU interrupt request is raised at the start of every frame, and software times its raster effects from that point. One T-state is roughly 290 ns, which gives a CPU clock of about 3.5 MHz.

The block watches CPU I/O writes. A write to the border port latches a three-bit colour. The border output picks up that latched colour again at every four-T-state boundary, which covers eight pixel slots, so writes made in the middle of a line show up as bands at that granularity. Two timing modes are selected by a pin. The base mode uses 224 T-states per line and 312 lines per frame (69888 T-states). The extended mode uses 228 T-states per line and 311 lines per frame (70908 T-states). In extended mode a second port selects the display bank. The bank output follows a write on the very next cycle, so the change reaches the frame already being drawn.

Top module: `raster_timer`

## Requirements
- R1: While `rst_n` is low, the T-state counter and the line counter are 0, the border is 0 (black) and the bank select is 0.
- R2: The T-state counter rises by one each clock and wraps to 0 after 223 in base mode (`mode_ext`=0) or after 227 in extended mode (`mode_ext`=1).
- R3: The line counter rises by one whenever the T-state counter wraps, and returns to 0 after line 311 in base mode or line 310 in extended mode.
- R4: `irq` is high exactly while the line counter is 0 and the T-state counter is below 32, which is once per frame for 32 cycles.
- R5: An I/O write whose address bit 0 is 0 stores data bits 2:0 as the border colour. Such a write at clock edge n becomes the stored colour after edge n.
- R6: The `border` output changes only at the edge that leaves a T-state count divisible by four. At that edge it takes the colour stored before the edge.
- R7: In extended mode, an I/O write whose address bit 15 is 0 and whose address bit 1 is 0 sets `bank_sel` to data bit 3 from the next cycle on. It does not wait for the next frame.
- R8: In base mode, writes that match the bank port decode leave `bank_sel` unchanged.
- R9: A write with address bits 0, 1 and 15 all set to 1 changes neither the border nor the bank select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ext | input | 1 | 0 selects base timing, 1 selects extended timing |
| io_wr | input | 1 | CPU I/O write strobe, one cycle per write |
| io_addr | input | 16 | CPU I/O address |
| io_data | input | 8 | CPU I/O write data |
| line_t | output | 8 | T-state position within the scanline |
| line_num | output | 9 | Scanline number within the frame |
| irq | output | 1 | Frame interrupt request, active high |
| border | output | 3 | Border colour for the current eight-pixel cell |
| bank_sel | output | 1 | Display bank used for the current fetch |

## Verification
The assertions assume that `mode_ext` changes only while reset is held. The wrap and bank-stability properties rely on the selected line length staying the same from one cycle to the next. The bench keeps to this by switching modes only while the block is in reset. It runs a complete frame in each mode and compares every counter and output cycle by cycle against arithmetic models. During those frames it mixes border writes, bank writes and decoy writes at changing phases within the four-T-state cells.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int BASE_LINE_T = 224,
  parameter int BASE_LINES  = 312,
  parameter int EXT_LINE_T  = 228,
  parameter int EXT_LINES   = 311,
  parameter int IRQ_T       = 32,
  parameter int CELL_T      = 4,
  localparam int TW = $clog2(EXT_LINE_T > BASE_LINE_T ? EXT_LINE_T : BASE_LINE_T),
  localparam int LW = $clog2(EXT_LINES > BASE_LINES ? EXT_LINES : BASE_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ext,
  input  logic          io_wr,
  input  logic [15:0]   io_addr,
  input  logic [7:0]    io_data,
  output logic [TW-1:0] line_t,
  output logic [LW-1:0] line_num,
  output logic          irq,
  output logic [2:0]    border,
  output logic          bank_sel
);
  logic [TW-1:0] t_last;
  logic [LW-1:0] l_last;
  logic [2:0]    fe_q;
  logic          fe_hit, bank_hit, cell_edge;

  assign t_last    = mode_ext ? TW'(EXT_LINE_T - 1) : TW'(BASE_LINE_T - 1);
  assign l_last    = mode_ext ? LW'(EXT_LINES - 1)  : LW'(BASE_LINES - 1);
  assign fe_hit    = io_wr && !io_addr[0];
  assign bank_hit  = io_wr && mode_ext && !io_addr[15] && !io_addr[1];
  assign cell_edge = (32'(line_t) % CELL_T) == 0;
  assign irq       = (line_num == '0) && (32'(line_t) < IRQ_T);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_t   <= '0;
      line_num <= '0;
      fe_q     <= '0;
      border   <= '0;
      bank_sel <= 1'b0;
    end else begin
      if (line_t >= t_last) begin
        line_t   <= '0;
        line_num <= (line_num >= l_last) ? '0 : line_num + 1'b1;
      end else begin
        line_t <= line_t + 1'b1;
      end
      if (fe_hit)    fe_q     <= io_data[2:0];
      if (cell_edge) border   <= fe_q;
      if (bank_hit)  bank_sel <= io_data[3];
    end
  end

  p_twrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_t == t_last) |=> (line_t == '0));
  p_tstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_t != t_last) |=> (line_t == $past(line_t) + 1'b1));
  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_t != t_last) |=> $stable(line_num));
  p_line_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_t == t_last && line_num == l_last) |=> (line_num == '0));
  p_irq_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (line_num == '0 && line_t == '0));
  p_irq_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (32'(line_t) == IRQ_T));
  p_border_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_edge |=> $stable(border));
  p_bank_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ext |=> $stable(bank_sel));
  p_bank_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hit |=> (bank_sel == $past(io_data[3])));
endmodule

// File: tb/raster_timer_tb.sv
`timescale 1ns/1ps
module raster_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, mode_ext = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_data = '0;
  logic [7:0]  line_t;
  logic [8:0]  line_num;
  logic        irq, bank_sel;
  logic [2:0]  border;

  int n_chk = 0, n_fail = 0;
  int exp_t, exp_l, exp_fe, exp_b, exp_bank, line_len, frame_lines;
  bit done = 0;

  always #2.5 clk = ~clk;

  raster_timer u_dut (.clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .io_wr(io_wr),
    .io_addr(io_addr), .io_data(io_data), .line_t(line_t), .line_num(line_num),
    .irq(irq), .border(border), .bank_sel(bank_sel));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (line %0d t %0d)", req, act, exp, exp_l, exp_t);
    end
  endtask

  task automatic check_all();
    chk("R2 t-state", line_t, exp_t);
    chk("R3 line", line_num, exp_l);
    chk("R4 irq", irq, (exp_l == 0 && exp_t < 32) ? 1 : 0);
    chk("R5/R6/R9 border", border, exp_b);
    chk("R7/R8/R9 bank", bank_sel, exp_bank);
  endtask

  task automatic cyc(input bit wr, input logic [15:0] a, input logic [7:0] d);
    io_wr = wr; io_addr = a; io_data = d;
    @(posedge clk);
    if (exp_t % 4 == 0) exp_b = exp_fe;
    if (wr && !a[0]) exp_fe = d[2:0];
    if (wr && mode_ext && !a[15] && !a[1]) exp_bank = d[3];
    if (exp_t == line_len - 1) begin
      exp_t = 0;
      exp_l = (exp_l == frame_lines - 1) ? 0 : exp_l + 1;
    end else exp_t++;
    @(negedge clk);
    io_wr = 1'b0;
    check_all();
  endtask

  task automatic run_mode(input bit ext);
    rst_n = 1'b0; mode_ext = ext;
    repeat (3) @(negedge clk);
    exp_t = 0; exp_l = 0; exp_fe = 0; exp_b = 0; exp_bank = 0;
    line_len = ext ? 228 : 224;
    frame_lines = ext ? 311 : 312;
    chk("R1 reset t", line_t, 0);
    chk("R1 reset line", line_num, 0);
    chk("R1 reset border", border, 0);
    chk("R1 reset bank", bank_sel, 0);
    rst_n = 1'b1;
    for (int i = 0; i < line_len * frame_lines + 300; i++) begin
      if (i % 37 == 5)       cyc(1'b1, {i[15:8], 8'hFE}, i[7:0]);
      else if (i % 53 == 7)  cyc(1'b1, 16'h7FFD, i[9:2]);
      else if (i % 41 == 3)  cyc(1'b1, 16'hFFFD, 8'hFF);
      else                   cyc(1'b0, 16'h0000, 8'h00);
    end
  endtask

  initial begin
    @(negedge clk);
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #990000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule